// File: doc/BRIEF.md
# DDR Read Latency and Burst Output Scheduler

This block is a cycle-based behavioural model of the read output side of a double-data-rate SDRAM. It registers READ commands on the rising clock edge, each with a bank address and a starting column. The command is held back by a programmable CAS latency of two or three cycles. The burst is then driven as a pair of beats per cycle: one for the rising half and one for the falling half. The beat data comes from a fixed word pattern built from the bank and column, so no storage array is needed. A strobe indicator comes out alongside the data. It is high in the rising half and low in the falling half, so it changes level with every beat, in step with the data edges.

Latency and burst length come from a configuration load port. A latency code other than two or three is rejected. It raises a sticky error flag, and the block ignores READ commands until a valid code is loaded. A READ issued exactly half a burst length after the previous one gives back-to-back output. A READ issued sooner cuts the earlier burst short.

Top module: `ddr_rd_sched`

## Requirements
- R1: A synchronous active-high reset clears every output to zero and clears the error flag. It selects a CAS latency of 3 and a burst length of 4.
- R2: When `cfg_load` is sampled high with `cfg_cl` equal to 2 or 3, that value becomes the latency. `cfg_bl` selects the burst length: 0 gives 2, 1 gives 4, and 2 or 3 give 8. Both take effect for READs sampled on later edges.
- R3: A READ sampled at rising edge n with latency CL loads its first beat pair into the output registers at edge n+CL.
- R4: A burst of length BL keeps `rd_valid` high for BL/2 consecutive cycles. Within each cycle, `rd_rise` carries the even beat and `rd_fall` the odd beat.
- R5: Beat i of a burst uses the column whose low log2(BL) bits are (start + i) mod BL. The upper column bits are those of the start column, so the order wraps inside the aligned block.
- R6: Each beat's data is the 8-bit word {bank[1:0], column[5:0]} XOR 0x5A.
- R7: While `rd_valid` is low, `rd_rise`, `rd_fall`, `rd_dqs_hi` and `rd_dqs_lo` are all zero.
- R8: While `rd_valid` is high, `rd_dqs_hi` is 1 and `rd_dqs_lo` is 0, so the strobe changes level once per beat.
- R9: A READ sampled exactly BL/2 edges after the previous READ makes its first beat pair follow the previous burst's last pair with no idle cycle.
- R10: A READ sampled fewer than BL/2 edges after the previous READ starts its own burst at its own edge n+CL. That burst replaces the remainder of the earlier one.
- R11: A load with any `cfg_cl` code other than 2 or 3 sets `cfg_err` and leaves the latency and burst length unchanged. The flag stays set until a load with a valid code. While it is set, READs produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load latency and burst length from the two fields below |
| cfg_cl | input | 3 | CAS latency code; 2 and 3 are valid |
| cfg_bl | input | 2 | Burst length code: 0=2, 1=4, 2 or 3=8 |
| cmd_rd | input | 1 | READ command, sampled on the rising edge |
| cmd_bank | input | 2 | Bank address of the READ |
| cmd_col | input | 6 | Starting column of the READ |
| rd_valid | output | 1 | Beat pair on the data outputs is valid |
| rd_rise | output | 8 | Beat driven in the rising half of the cycle |
| rd_fall | output | 8 | Beat driven in the falling half of the cycle |
| rd_dqs_hi | output | 1 | Strobe level during the rising half |
| rd_dqs_lo | output | 1 | Strobe level during the falling half |
| cfg_err | output | 1 | Sticky flag for a rejected latency code |

## Verification
A wrong latency tap or pipeline stage moves the whole burst by a cycle. That shows on `rd_valid` at edge n+CL, the first cycle the burst should appear. A wrong pair counter or column mask shows up as a wrong beat word on `rd_rise` or `rd_fall` within BL/2 cycles, or as a burst that is one cycle too long or too short. A faulty error flag or truncation path shows at the next READ, as a burst that should not exist or a stale beat where the new burst should be. The reference model compares every output on every cycle, so each of these faults is caught in the cycle it first appears.

// File: rtl/ddr_rd_pkg.sv
`timescale 1ns/1ps
package ddr_rd_pkg;

  localparam int CL_W = 3;

  typedef enum logic [1:0] {
    BLC_TWO   = 2'd0,
    BLC_FOUR  = 2'd1,
    BLC_EIGHT = 2'd2,
    BLC_EIGHT_ALT = 2'd3
  } bl_code_e;

  // Only latencies of two and three cycles are legal.
  function automatic logic cl_code_ok(input logic [CL_W-1:0] code);
    return (code == CL_W'(2)) || (code == CL_W'(3));
  endfunction

  // Burst length as an offset mask (BL-1).
  function automatic logic [2:0] bl_mask_of(input logic [1:0] code);
    case (bl_code_e'(code))
      BLC_TWO:  return 3'b001;
      BLC_FOUR: return 3'b011;
      default:  return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/ddr_rd_cfg.sv
`timescale 1ns/1ps
module ddr_rd_cfg
  import ddr_rd_pkg::*;
#(
  parameter int OFS_W = 3
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CL_W-1:0]  cl_code,
  input  logic [1:0]       bl_code,
  output logic [CL_W-1:0]  cl_q,
  output logic [OFS_W-1:0] mask_q,
  output logic             err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q   <= CL_W'(3);
      mask_q <= OFS_W'(3);
      err_q  <= 1'b0;
    end else if (load) begin
      if (cl_code_ok(cl_code)) begin
        cl_q   <= cl_code;
        mask_q <= OFS_W'(bl_mask_of(bl_code));
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_rd_lat_pipe.sv
`timescale 1ns/1ps
module ddr_rd_lat_pipe #(
  parameter int DEPTH = 3,
  parameter int W     = 8,
  localparam int SEL_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [W-1:0]     in_data,
  input  logic [SEL_W-1:0] tap,
  output logic             out_vld,
  output logic [W-1:0]     out_data
);

  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];

  // Valid bits carry reset; payload is a plain shift line (shift-register friendly).
  always_ff @(posedge clk) begin
    if (rst) vld_q[0] <= 1'b0;
    else     vld_q[0] <= in_vld;
    dat_q[0] <= in_data;
  end

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) vld_q[k] <= 1'b0;
        else     vld_q[k] <= vld_q[k-1];
        dat_q[k] <= dat_q[k-1];
      end
    end
  endgenerate

  assign out_vld  = vld_q[tap];
  assign out_data = dat_q[tap];

endmodule

// File: rtl/ddr_rd_burst.sv
`timescale 1ns/1ps
module ddr_rd_burst #(
  parameter int BANK_W   = 2,
  parameter int COL_W    = 6,
  parameter int OFS_W    = 3,
  parameter int PAT_SEED = 'h5A,
  localparam int DATA_W  = BANK_W + COL_W,
  localparam int PAIR_W  = OFS_W - 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [BANK_W-1:0] l_bank,
  input  logic [COL_W-1:0]  l_col,
  input  logic [OFS_W-1:0]  mask,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_rise,
  output logic [DATA_W-1:0] o_fall,
  output logic              o_dqs_hi,
  output logic              o_dqs_lo
);

  logic              act_q, n_act;
  logic [BANK_W-1:0] bank_q, n_bank;
  logic [COL_W-1:0]  col_q, n_col;
  logic [OFS_W-1:0]  mask_q, n_mask;
  logic [PAIR_W-1:0] pair_q, n_pair;
  logic [PAIR_W-1:0] last_pair;

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] start,
    input logic [OFS_W-1:0] m,
    input logic [OFS_W-1:0] idx
  );
    logic [COL_W-1:0] mw;
    logic [OFS_W-1:0] lo;
    mw = {{(COL_W-OFS_W){1'b0}}, m};
    lo = (start[OFS_W-1:0] + idx) & m;
    return (start & ~mw) | {{(COL_W-OFS_W){1'b0}}, lo};
  endfunction

  function automatic logic [DATA_W-1:0] beat_word(
    input logic [BANK_W-1:0] b,
    input logic [COL_W-1:0]  c
  );
    return {b, c} ^ DATA_W'(PAT_SEED);
  endfunction

  assign last_pair = mask_q[OFS_W-1:1];

  always_comb begin
    n_act  = act_q;
    n_bank = bank_q;
    n_col  = col_q;
    n_mask = mask_q;
    n_pair = pair_q;
    if (launch) begin
      n_act  = 1'b1;
      n_bank = l_bank;
      n_col  = l_col;
      n_mask = mask;
      n_pair = '0;
    end else if (act_q && pair_q == last_pair) begin
      n_act  = 1'b0;
    end else if (act_q) begin
      n_pair = pair_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      bank_q   <= '0;
      col_q    <= '0;
      mask_q   <= '0;
      pair_q   <= '0;
      o_valid  <= 1'b0;
      o_rise   <= '0;
      o_fall   <= '0;
      o_dqs_hi <= 1'b0;
      o_dqs_lo <= 1'b0;
    end else begin
      act_q    <= n_act;
      bank_q   <= n_bank;
      col_q    <= n_col;
      mask_q   <= n_mask;
      pair_q   <= n_pair;
      o_valid  <= n_act;
      o_dqs_hi <= n_act;
      o_dqs_lo <= 1'b0;
      if (n_act) begin
        o_rise <= beat_word(n_bank, beat_col(n_col, n_mask, {n_pair, 1'b0}));
        o_fall <= beat_word(n_bank, beat_col(n_col, n_mask, {n_pair, 1'b1}));
      end else begin
        o_rise <= '0;
        o_fall <= '0;
      end
    end
  end

endmodule

// File: rtl/ddr_rd_sched.sv
`timescale 1ns/1ps
module ddr_rd_sched
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int COL_W    = 6,
  parameter int MAX_BL   = 8,
  parameter int MAX_CL   = 3,
  parameter int PAT_SEED = 'h5A
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_load,
  input  logic [2:0]               cfg_cl,
  input  logic [1:0]               cfg_bl,
  input  logic                     cmd_rd,
  input  logic [BANK_W-1:0]        cmd_bank,
  input  logic [COL_W-1:0]         cmd_col,
  output logic                     rd_valid,
  output logic [BANK_W+COL_W-1:0]  rd_rise,
  output logic [BANK_W+COL_W-1:0]  rd_fall,
  output logic                     rd_dqs_hi,
  output logic                     rd_dqs_lo,
  output logic                     cfg_err
);

  localparam int DATA_W = BANK_W + COL_W;
  localparam int OFS_W  = $clog2(MAX_BL);
  localparam int TAP_W  = $clog2(MAX_CL);
  localparam int CMD_W  = BANK_W + COL_W;

  logic [CL_W-1:0]  cl_q;
  logic [OFS_W-1:0] mask_q;
  logic             err_q;
  logic             accept;
  logic [TAP_W-1:0] tap;
  logic             launch;
  logic [CMD_W-1:0] launch_cmd;

  ddr_rd_cfg #(.OFS_W(OFS_W)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .load    (cfg_load),
    .cl_code (cfg_cl),
    .bl_code (cfg_bl),
    .cl_q    (cl_q),
    .mask_q  (mask_q),
    .err_q   (err_q)
  );

  assign accept = cmd_rd && !err_q;
  assign tap    = TAP_W'(cl_q - CL_W'(1));

  ddr_rd_lat_pipe #(.DEPTH(MAX_CL), .W(CMD_W)) pipe_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (accept),
    .in_data  ({cmd_bank, cmd_col}),
    .tap      (tap),
    .out_vld  (launch),
    .out_data (launch_cmd)
  );

  ddr_rd_burst #(
    .BANK_W   (BANK_W),
    .COL_W    (COL_W),
    .OFS_W    (OFS_W),
    .PAT_SEED (PAT_SEED)
  ) burst_i (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .l_bank   (launch_cmd[CMD_W-1:COL_W]),
    .l_col    (launch_cmd[COL_W-1:0]),
    .mask     (mask_q),
    .o_valid  (rd_valid),
    .o_rise   (rd_rise),
    .o_fall   (rd_fall),
    .o_dqs_hi (rd_dqs_hi),
    .o_dqs_lo (rd_dqs_lo)
  );

  assign cfg_err = err_q;

endmodule

// File: rtl/ddr_rd_sched_chk.sv
`timescale 1ns/1ps
module ddr_rd_sched_chk #(
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rst,
  input logic              cmd_rd,
  input logic              cfg_load,
  input logic              cfg_err,
  input logic [2:0]        cl_cur,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_rise,
  input logic [DATA_W-1:0] rd_fall,
  input logic              rd_dqs_hi,
  input logic              rd_dqs_lo
);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_rise == '0 && rd_fall == '0 && !rd_dqs_hi && !rd_dqs_lo));

  assert_strobe_phase_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_dqs_hi && !rd_dqs_lo));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !cfg_load) |=> cfg_err);

  assert_latency_two_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_valid) && cl_cur == 3'd2) |-> $past(cmd_rd, 3));

  assert_latency_three_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_valid) && cl_cur == 3'd3) |-> $past(cmd_rd, 4));

endmodule

bind ddr_rd_sched ddr_rd_sched_chk #(.DATA_W(BANK_W + COL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_rd    (cmd_rd),
  .cfg_load  (cfg_load),
  .cfg_err   (cfg_err),
  .cl_cur    (cl_q),
  .rd_valid  (rd_valid),
  .rd_rise   (rd_rise),
  .rd_fall   (rd_fall),
  .rd_dqs_hi (rd_dqs_hi),
  .rd_dqs_lo (rd_dqs_lo)
);

// File: tb/ddr_rd_sched_tb_top.sv
`timescale 1ns/1ps
module ddr_rd_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [2:0] cfg_cl = 3'd0;
  logic [1:0] cfg_bl = 2'd0;
  logic       cmd_rd = 1'b0;
  logic [1:0] cmd_bank = 2'd0;
  logic [5:0] cmd_col = 6'd0;
  logic       rd_valid, rd_dqs_hi, rd_dqs_lo, cfg_err;
  logic [7:0] rd_rise, rd_fall;

  always #2.5 clk = ~clk;

  ddr_rd_sched dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
    .cmd_rd(cmd_rd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .rd_valid(rd_valid), .rd_rise(rd_rise), .rd_fall(rd_fall),
    .rd_dqs_hi(rd_dqs_hi), .rd_dqs_lo(rd_dqs_lo), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_err = 0;
  int edge_no = 0;
  int m_cl = 3;
  int m_bl = 4;
  bit m_err = 1'b0;
  int exp_v [int];
  int exp_r [int];
  int exp_f [int];
  string tag = "R1";
  bit done = 1'b0;

  function automatic int pat(int b, int c);
    return ((b << 6) | c) ^ 'h5A;
  endfunction

  function automatic int bcol(int s, int bl, int i);
    return (s & ~(bl - 1)) | ((s + i) & (bl - 1));
  endfunction

  task automatic check(string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h (edge %0d)", tag, what, act, expv, edge_no);
    end
  endtask

  task automatic step(bit rd = 0, int b = 0, int c = 0, bit ld = 0, int clc = 0, int blc = 0);
    cmd_rd   = rd;
    cmd_bank = 2'(b);
    cmd_col  = 6'(c);
    cfg_load = ld;
    cfg_cl   = 3'(clc);
    cfg_bl   = 2'(blc);
    @(posedge clk);
    edge_no++;
    if (rd && !m_err && !rst) begin
      int s;
      s = edge_no + m_cl;
      for (int k = s; k < s + 24; k++) begin
        exp_v.delete(k); exp_r.delete(k); exp_f.delete(k);
      end
      for (int p = 0; p < m_bl / 2; p++) begin
        exp_v[s + p] = 1;
        exp_r[s + p] = pat(b, bcol(c, m_bl, 2 * p));
        exp_f[s + p] = pat(b, bcol(c, m_bl, 2 * p + 1));
      end
    end
    if (ld && !rst) begin
      if (clc == 2 || clc == 3) begin
        m_cl = clc;
        m_bl = (blc == 0) ? 2 : (blc == 1) ? 4 : 8;
        m_err = 1'b0;
      end else begin
        m_err = 1'b1;
      end
    end
    @(negedge clk);
    begin
      int ev, er, ef;
      ev = exp_v.exists(edge_no) ? 1 : 0;
      er = exp_r.exists(edge_no) ? exp_r[edge_no] : 0;
      ef = exp_f.exists(edge_no) ? exp_f[edge_no] : 0;
      check("rd_valid", int'(rd_valid), ev);
      check("rd_rise", int'(rd_rise), er);
      check("rd_fall", int'(rd_fall), ef);
      check("rd_dqs_hi", int'(rd_dqs_hi), ev);
      check("rd_dqs_lo", int'(rd_dqs_lo), 0);
      check("cfg_err", int'(cfg_err), int'(m_err));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    // R1: reset state, defaults CL=3 BL=4
    tag = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 R3 R4 R5 R6: default latency 3, burst 4, bank 1 col 5 -> 5,6,7,4
    tag = "R1 R3 R5 R6 default";
    step(1, 1, 5);
    idle(10);

    // R2 R3: load CL=2, BL=4
    tag = "R2 R3 cl2";
    step(0, 0, 0, 1, 2, 1);
    step(1, 3, 6);
    idle(8);

    // R2 R4 R5: CL=3, BL=8, col 3 wraps within 0..7
    tag = "R2 R4 R5 bl8";
    step(0, 0, 0, 1, 3, 2);
    step(1, 2, 3);
    idle(12);
    step(1, 0, 61);
    idle(12);

    // R2: code 3 also gives BL=8, R5 with upper column bits kept
    tag = "R2 R5 blcode3";
    step(0, 0, 0, 1, 2, 3);
    step(1, 1, 45);
    idle(10);

    // R2 R4 R7: BL=2, col 9 -> 9,8
    tag = "R2 R4 R7 bl2";
    step(0, 0, 0, 1, 2, 0);
    step(1, 2, 9);
    idle(6);

    // R9: seamless back-to-back with BL=4 CL=2
    tag = "R9 seamless";
    step(0, 0, 0, 1, 2, 1);
    step(1, 0, 1);
    step();
    step(1, 3, 2);
    step();
    step(1, 1, 7);
    idle(8);

    // R10: truncation, reads one cycle apart, and CL=3 BL=8 two apart
    tag = "R10 truncate";
    step(1, 2, 12);
    step(1, 1, 20);
    idle(8);
    step(0, 0, 0, 1, 3, 2);
    step(1, 0, 8);
    step();
    step(1, 3, 33);
    idle(12);

    // R11: reserved code sets error, reads ignored, settings kept
    tag = "R11 reserved";
    step(0, 0, 0, 1, 5, 0);
    step(1, 1, 1);
    idle(8);
    step(0, 0, 0, 1, 0, 1);
    step(1, 2, 2);
    idle(8);
    tag = "R11 clear";
    step(0, 0, 0, 1, 2, 1);
    step(1, 3, 14);
    idle(8);

    // R8 R7: strobe checks accumulate on all cycles above; final idle stretch
    tag = "R7 R8 tail";
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule